// File: doc/BRIEF.md
# Luma Block-Border Coring Filter

The block sits in a digital video output path and cleans up, or crispens, the luma of a line-ordered sample stream. Samples arrive one per clock cycle and a pixel spans two of them. The first sample after a line start is the colour-difference sample of pixel 0, and the second is its luma. After that the two kinds alternate. A three-tap horizontal high-pass filter runs on the luma samples. The magnitude of its output is compared with a programmable threshold.

In noise-reduction mode, small high-frequency content is treated as noise and a scaled share of it is removed. In sharpening mode, large content is treated as real detail and a scaled share is added. The block keeps a horizontal pixel position that wraps on a grid of 8- or 16-pixel coding blocks. The grid can be shifted by a programmable offset. Pixels next to a block edge use a border gain and all other pixels use an inner gain, so compression artefacts at block seams can be handled separately.

Within a line, `in_valid` is held high on every cycle. Between lines it is low, or the next line begins directly with a new line start.

Top module: `luma_border_coring`

## Requirements
- R1: Colour-difference samples pass through unchanged. These are the samples of phase 0: the sample marked by `in_line_start`, and then every second valid sample after it.
- R2: For each luma sample c, the filter output is hp = floor((2c - p - n) / 4). Here p and n are the luma samples of the previous and next pixel of the same line. At the first and last pixel of a line, the missing neighbour is replaced by c.
- R3: With `cfg_sharpen`=0, when |hp| < `cfg_thresh` the output is c - floor(hp*g/8). Otherwise the output is c, so an equal magnitude leaves the sample unchanged. A threshold of 0 leaves every sample unchanged.
- R4: With `cfg_sharpen`=1, when |hp| > `cfg_thresh` the output is c + floor(hp*g/16). Otherwise the output is c.
- R5: The gain g is the selected 4-bit gain code limited to 8, so codes 9 to 15 act as 8. A gain of 0 leaves the sample unchanged.
- R6: The pixel position within a block is b = (pixel index - `cfg_offset`) mod W. The block width W is 8 when `cfg_block16`=0 and 16 when `cfg_block16`=1. Border pixels use `cfg_gain_border` and all other pixels use `cfg_gain_inner`.
- R7: With `cfg_wide_border`=0, a pixel is a border pixel when b is 0 or W-1. With `cfg_wide_border`=1, it is a border pixel when b is 0, 1, W-2 or W-1.
- R8: The 4-bit `cfg_offset` moves every block edge right by that many pixels, counted from pixel 0 of the line.
- R9: The luma result is clamped to the range 0 to 255.
- R10: `out_valid`, `out_line_start` and `out_data` follow the corresponding input by exactly 3 clock cycles.
- R11: While reset is held and directly after it, `out_valid` and `out_line_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_line_start | input | 1 | Marks the first sample of a line (chroma of pixel 0) |
| in_data | input | 8 | Input sample, chroma and luma interleaved |
| cfg_sharpen | input | 1 | 0 selects noise reduction, 1 selects sharpening |
| cfg_thresh | input | 6 | Magnitude threshold, 0 to 63 |
| cfg_gain_border | input | 4 | Gain code for border pixels |
| cfg_gain_inner | input | 4 | Gain code for inner pixels |
| cfg_block16 | input | 1 | Block width: 0 gives 8 pixels, 1 gives 16 pixels |
| cfg_wide_border | input | 1 | Border width: 0 gives one pixel per side, 1 gives two |
| cfg_offset | input | 4 | Grid shift in pixels |
| out_valid | output | 1 | Output sample valid |
| out_line_start | output | 1 | Delayed line-start marker |
| out_data | output | 8 | Output sample |

## Verification
The case that is hardest to reach from the ports combines three things on one pixel: a wide border, a 16-pixel grid, and an offset that makes the border wrap across the block seam. That pixel must also receive a filter magnitude that lands exactly on the threshold. The bench sets the border gain to full strength and the inner gain to zero, so that each pixel's class shows in its output value. It then drives long lines with a pseudo-random luma pattern under several offsets and block widths. A separate line alternates between two levels, which holds the filter magnitude at exactly 4, and the threshold is set to 4 in both modes.

// File: rtl/luma_border_coring.sv
module luma_border_coring #(
  parameter int DW = 8,
  parameter int TW = 6,
  parameter int GW = 4,
  parameter int PW = 4,
  parameter int GMAX = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_line_start,
  input  logic [DW-1:0] in_data,
  input  logic          cfg_sharpen,
  input  logic [TW-1:0] cfg_thresh,
  input  logic [GW-1:0] cfg_gain_border,
  input  logic [GW-1:0] cfg_gain_inner,
  input  logic          cfg_block16,
  input  logic          cfg_wide_border,
  input  logic [PW-1:0] cfg_offset,
  output logic          out_valid,
  output logic          out_line_start,
  output logic [DW-1:0] out_data
);
  localparam int SW = DW + 3;
  localparam int XW = SW + GW + 1;
  localparam int YMAX = (1 << DW) - 1;

  logic          ph_q;
  logic [PW-1:0] cnt;
  logic [DW-1:0] d1, d2, d3, d4;
  logic [4:1]    v, ls;
  logic          ph1, ph2;
  logic [PW-1:0] ix1, ix2;

  wire          ph_in  = in_line_start ? 1'b0 : ~ph_q;
  wire [PW-1:0] idx_in = in_line_start ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= 1'b1;
      cnt  <= '0;
      v    <= '0;
      ls   <= '0;
      ph1  <= 1'b0;
      ph2  <= 1'b0;
      ix1  <= '0;
      ix2  <= '0;
      d1   <= '0;
      d2   <= '0;
      d3   <= '0;
      d4   <= '0;
    end else begin
      if (in_valid) begin
        ph_q <= ph_in;
        cnt  <= ph_in ? idx_in + 1'b1 : idx_in;
      end
      v   <= {v[3:1], in_valid};
      ls  <= {ls[3:1], in_valid & in_line_start};
      ph1 <= ph_in;
      ph2 <= ph1;
      ix1 <= idx_in;
      ix2 <= ix1;
      d1  <= in_data;
      d2  <= d1;
      d3  <= d2;
      d4  <= d3;
    end
  end

  wire          prev_ok = v[4] & ~ls[3];
  wire          next_ok = in_valid & v[1] & ~ls[1];
  wire [DW-1:0] c = d2;
  wire [DW-1:0] p = prev_ok ? d4 : c;
  wire [DW-1:0] n = next_ok ? in_data : c;

  wire signed [SW-1:0] s  = $signed({2'b0, c, 1'b0}) - $signed({3'b0, p}) - $signed({3'b0, n});
  wire signed [SW-1:0] hp = s >>> 2;
  wire        [SW-1:0] mag = hp[SW-1] ? -hp : hp;

  wire [PW-1:0] b    = (ix2 - cfg_offset) & (cfg_block16 ? 4'd15 : 4'd7);
  wire [PW-1:0] last = cfg_block16 ? 4'd15 : 4'd7;
  wire border = cfg_wide_border ? (b <= 4'd1 || b >= last - 4'd1)
                                : (b == 4'd0 || b == last);

  wire [GW-1:0] gsel = border ? cfg_gain_border : cfg_gain_inner;
  wire [GW-1:0] g    = (gsel > GW'(GMAX)) ? GW'(GMAX) : gsel;

  wire signed [XW-1:0] prod = hp * $signed({1'b0, g});
  wire signed [XW-1:0] adj  = cfg_sharpen ? (prod >>> 4) : (prod >>> 3);
  wire act = cfg_sharpen ? (mag > SW'(cfg_thresh)) : (mag < SW'(cfg_thresh));

  wire signed [XW-1:0] base = $signed({{(XW-DW){1'b0}}, c});
  wire signed [XW-1:0] sum  = !act ? base : (cfg_sharpen ? base + adj : base - adj);

  logic [DW-1:0] luma_out;
  always_comb begin
    if (sum < 0)                 luma_out = '0;
    else if (sum > XW'(YMAX))    luma_out = DW'(YMAX);
    else                         luma_out = sum[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_line_start <= 1'b0;
      out_data       <= '0;
    end else begin
      out_valid      <= v[2];
      out_line_start <= ls[2];
      out_data       <= ph2 ? luma_out : d2;
    end
  end
endmodule

// File: rtl/luma_border_coring_chk.sv
module luma_border_coring_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_line_start,
  input logic [7:0] in_data,
  input logic       cfg_sharpen,
  input logic [5:0] cfg_thresh,
  input logic [3:0] cfg_gain_border,
  input logic [3:0] cfg_gain_inner,
  input logic       cfg_block16,
  input logic       cfg_wide_border,
  input logic [3:0] cfg_offset,
  input logic       out_valid,
  input logic       out_line_start,
  input logic [7:0] out_data
);
  logic [1:0] seen;
  logic       phq;
  wire        ph_now = in_line_start ? 1'b0 : ~phq;
  wire        ok = (seen == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
      phq  <= 1'b1;
    end else begin
      if (!ok) seen <= seen + 2'd1;
      if (in_valid) phq <= ph_now;
    end
  end

  a_r10_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (out_valid == $past(in_valid, 3) && out_line_start == $past(in_valid && in_line_start, 3)));

  a_r1_chroma_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && $past(in_valid && !ph_now, 3)) |-> out_data == $past(in_data, 3));

  a_r5_zero_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && $past(in_valid && ph_now, 3) && $past(cfg_gain_border == 4'd0 && cfg_gain_inner == 4'd0))
      |-> out_data == $past(in_data, 3));

  a_r3_zero_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && $past(in_valid && ph_now, 3) && $past(!cfg_sharpen && cfg_thresh == 6'd0))
      |-> out_data == $past(in_data, 3));

  a_r11_reset_quiet: assert property (@(posedge clk)
    !$past(rst_n) |-> (!out_valid && !out_line_start));
endmodule

bind luma_border_coring luma_border_coring_chk u_chk (.*);

// File: tb/luma_border_coring_tb.sv
module luma_border_coring_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_line_start = 0;
  logic [7:0] in_data = 0;
  logic cfg_sharpen = 0, cfg_block16 = 0, cfg_wide_border = 0;
  logic [5:0] cfg_thresh = 0;
  logic [3:0] cfg_gain_border = 0, cfg_gain_inner = 0, cfg_offset = 0;
  logic out_valid, out_line_start;
  logic [7:0] out_data;

  luma_border_coring u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int ymem[64], cmem[64], got[128];
  int ng = 0, ls_out_cyc = -1;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && out_valid) begin
    if (ng < 128) got[ng] = out_data;
    if (out_line_start) ls_out_cyc = cyc;
    ng++;
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R2..R9 model
  function automatic int model(int i, int np);
    int c, p, n, s, hp, mag, w, b, g, r;
    bit brd, act;
    c = ymem[i];
    p = (i > 0) ? ymem[i-1] : c;
    n = (i < np-1) ? ymem[i+1] : c;
    s = 2*c - p - n;
    hp = s >>> 2;
    mag = hp < 0 ? -hp : hp;
    w = cfg_block16 ? 16 : 8;
    b = ((i - int'(cfg_offset)) % w + w) % w;
    brd = cfg_wide_border ? (b <= 1 || b >= w-2) : (b == 0 || b == w-1);
    g = brd ? cfg_gain_border : cfg_gain_inner;
    if (g > 8) g = 8;
    act = cfg_sharpen ? (mag > cfg_thresh) : (mag < cfg_thresh);
    r = c;
    if (act) r = cfg_sharpen ? c + ((hp*g) >>> 4) : c - ((hp*g) >>> 3);
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic fill(int kind, int seed, int np);
    for (int i = 0; i < np; i++) begin
      cmem[i] = (i*13 + seed*7) % 256;
      case (kind)
        0: ymem[i] = (i*73 + seed*29 + (i*i) % 17) % 256;
        1: ymem[i] = 120 + (i*5 + seed) % 7;
        2: ymem[i] = (i % 2) ? 108 : 100;
        default: ymem[i] = (i % 4 < 2) ? 250 : 5;
      endcase
    end
  endtask

  task automatic run_line(string tag, int np);
    int st;
    ng = 0; ls_out_cyc = -1; st = 0;
    for (int k = 0; k < 2*np; k++) begin
      @(negedge clk);
      if (k == 0) st = cyc;
      in_valid = 1; in_line_start = (k == 0);
      in_data = 8'((k % 2) ? ymem[k/2] : cmem[k/2]);
    end
    @(negedge clk);
    in_valid = 0; in_line_start = 0;
    repeat (6) @(negedge clk);
    chk("R10 count", ng, 2*np);
    chk("R10 latency", ls_out_cyc - st, 3);
    for (int i = 0; i < np; i++) begin
      chk("R1 chroma", got[2*i], cmem[i]);
      chk(tag, got[2*i+1], model(i, np));
    end
  endtask

  task automatic cfg(bit sh, int th, int gb, int gi, bit b16, bit wide, int off);
    cfg_sharpen = sh; cfg_thresh = 6'(th); cfg_gain_border = 4'(gb);
    cfg_gain_inner = 4'(gi); cfg_block16 = b16; cfg_wide_border = wide; cfg_offset = 4'(off);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 valid", out_valid, 0);
    chk("R11 line_start", out_line_start, 0);
  endtask

  task automatic t_noise;
    cfg(0, 20, 8, 4, 0, 0, 0); fill(1, 3, 24); run_line("R3 ripple", 24);
    cfg(0, 40, 6, 2, 0, 0, 0); fill(0, 1, 24); run_line("R2 R3 mixed", 24);
  endtask

  task automatic t_sharpen;
    cfg(1, 10, 3, 8, 0, 0, 0); fill(0, 5, 30); run_line("R4 sharpen", 30);
  endtask

  task automatic t_equal;
    cfg(0, 4, 8, 8, 0, 0, 0); fill(2, 0, 16); run_line("R3 equal", 16);
    cfg(1, 4, 8, 8, 0, 0, 0); fill(2, 0, 16); run_line("R4 equal", 16);
  endtask

  task automatic t_clamp;
    cfg(1, 0, 8, 8, 0, 0, 0); fill(3, 0, 20); run_line("R9 clamp", 20);
  endtask

  task automatic t_gain_cap;
    cfg(0, 63, 15, 12, 0, 1, 0); fill(0, 2, 24); run_line("R5 cap", 24);
  endtask

  task automatic t_grid;
    cfg(0, 63, 8, 0, 1, 1, 0); fill(0, 4, 40); run_line("R6 R7 block16 wide", 40);
    cfg(0, 63, 8, 0, 0, 0, 0); fill(0, 6, 40); run_line("R6 R7 block8 narrow", 40);
  endtask

  task automatic t_offset;
    cfg(0, 63, 8, 0, 1, 1, 5);  fill(0, 7, 48); run_line("R8 off5 b16", 48);
    cfg(0, 63, 8, 0, 0, 0, 11); fill(0, 8, 40); run_line("R8 off11 b8", 40);
    cfg(1, 0, 0, 8, 1, 1, 15);  fill(0, 9, 48); run_line("R8 off15 sharpen", 48);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_reset;
    t_noise;
    t_sharpen;
    t_equal;
    t_clamp;
    t_gain_cap;
    t_grid;
    t_offset;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule